// File: doc/BRIEF.md
# DSP Register Load/Store Formatter

This block sits between a 32-bit memory data path and a small DSP register file. It receives one transfer command at a time. The command carries a register selector, a size (16-bit word or 32-bit longword) and a direction. For a load, it shapes the incoming bus value and writes it into the selected register. For a store, it reads the selected register and shapes the value it drives onto the outgoing bus.

The file holds two 40-bit accumulators. Each accumulator is a 32-bit body plus an 8-bit guard extension. The file also holds four plain 32-bit operand registers. Each guard extension can also be named on its own as a separate register. The status register is a reserved selector. Any command naming it is flagged and has no effect. Transfers never change any condition-code state.

Internally, a decoder classifies each cycle as idle, load, store or reject. A load aligner builds the register image from the bus. A register file holds the state. A store aligner builds the bus image from the register.

Top module: `dsp_xfer_fmt`

## Requirements
- R1: Selector encoding on `cmd_sel`: 0 and 1 are accumulators 0 and 1; 2 and 3 are the guard fields of accumulators 0 and 1; 4 to 7 are operand registers 0 to 3; 8 is the status register; 9 to 15 are unused. `cmd_load`=1 means load and 0 means store. `cmd_long`=1 means longword and 0 means word.
- R2: A synchronous active-high `rst` clears every register to zero, including both guard fields.
- R3: A word load to an accumulator or operand register writes `{ld_data[15:0], 16'h0000}` into its 32-bit body.
- R4: A longword load to an accumulator or operand register writes all 32 bits of `ld_data` into its body.
- R5: A load of either size into an accumulator also sets that accumulator's guard field to eight copies of bit 31 of the value written into the body.
- R6: A load of either size to a guard selector (2 or 3) writes `ld_data[7:0]` into that guard field only. The accumulator's 32-bit body and the other accumulator stay unchanged.
- R7: A store of either size from a guard selector drives the 8-bit guard value on `st_data[7:0]` and copies its bit 7 into `st_data[31:8]`.
- R8: A word store from an accumulator or operand register drives register bits 31:16 on `st_data[15:0]`, and copies register bit 31 into `st_data[31:16]`.
- R9: A longword store from an accumulator or operand register drives register bits 31:0 on `st_data`. The guard field does not appear on the bus.
- R10: A valid command with selector 8 to 15 raises `cmd_illegal` in the same cycle, changes no register and drives `st_data` to zero. `cmd_illegal` is low at all other times.
- R11: A load changes the register on the clock edge that samples the command, so a store in the next cycle already reads the new value. `st_data` is combinational from the current register contents. `st_data` is zero in any cycle without a valid legal store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_load | input | 1 | 1 = load into register, 0 = store from register |
| cmd_long | input | 1 | 1 = longword, 0 = word |
| cmd_sel | input | 4 | Register selector |
| ld_data | input | 32 | Load data from memory bus |
| st_data | output | 32 | Store data to memory bus |
| cmd_illegal | output | 1 | Command names a reserved selector |

## Verification
`st_data` and `cmd_illegal` are combinational and are due in the same cycle as the command. The effect of a load is due one clock edge later, and it becomes visible through a store issued in the following cycle.

The bench drives every command shortly after a rising edge. It records the expected bus value and flag for that same cycle. The monitor compares them at the following falling edge, so each result is checked in the cycle it belongs to.

Register contents are never read directly. They are observed only through stores: a longword store for the body and a guard-selector store for the extension.

// File: rtl/dsp_xfer_pkg.sv
`timescale 1ns/1ps
package dsp_xfer_pkg;
    localparam int DATA_W   = 32;
    localparam int GUARD_W  = 8;
    localparam int NUM_ACC  = 2;
    localparam int NUM_OPR  = 4;
    localparam int SEL_W    = 4;

    localparam logic [SEL_W-1:0] SEL_ACC_BASE = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_GRD_BASE = SEL_W'(NUM_ACC);
    localparam logic [SEL_W-1:0] SEL_OPR_BASE = SEL_W'(2 * NUM_ACC);
    localparam logic [SEL_W-1:0] SEL_LAST_OK  = SEL_W'(2 * NUM_ACC + NUM_OPR - 1);
    localparam logic [SEL_W-1:0] SEL_STATUS   = SEL_W'(2 * NUM_ACC + NUM_OPR);

    typedef enum logic [1:0] {
        XK_IDLE,
        XK_LOAD,
        XK_STORE,
        XK_REJECT
    } xfer_kind_e;
endpackage

// File: rtl/xfer_decode.sv
`timescale 1ns/1ps
module xfer_decode
    import dsp_xfer_pkg::*;
(
    input  logic             cmd_valid,
    input  logic             cmd_load,
    input  logic [SEL_W-1:0] cmd_sel,
    output xfer_kind_e       kind,
    output logic             sel_is_guard
);
    logic sel_legal;

    always_comb begin
        sel_legal    = (cmd_sel <= SEL_LAST_OK);
        sel_is_guard = (cmd_sel >= SEL_GRD_BASE) && (cmd_sel < SEL_OPR_BASE);
        if (!cmd_valid)      kind = XK_IDLE;
        else if (!sel_legal) kind = XK_REJECT;
        else if (cmd_load)   kind = XK_LOAD;
        else                 kind = XK_STORE;
    end
endmodule

// File: rtl/xfer_load_align.sv
`timescale 1ns/1ps
module xfer_load_align #(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8
) (
    input  logic               cmd_long,
    input  logic [DATA_W-1:0]  ld_data,
    output logic [DATA_W-1:0]  img_body,
    output logic [GUARD_W-1:0] img_guard,
    output logic [GUARD_W-1:0] grd_byte
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        if (cmd_long) img_body = ld_data;
        else          img_body = {ld_data[HALF_W-1:0], {HALF_W{1'b0}}};
        img_guard = {GUARD_W{img_body[DATA_W-1]}};
        grd_byte  = ld_data[GUARD_W-1:0];
    end
endmodule

// File: rtl/xfer_regfile.sv
`timescale 1ns/1ps
module xfer_regfile
    import dsp_xfer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DATA_W-1:0]  img_body,
    input  logic [GUARD_W-1:0] img_guard,
    input  logic [GUARD_W-1:0] grd_byte,
    output logic [DATA_W-1:0]  rd_body,
    output logic [GUARD_W-1:0] rd_guard
);
    logic [DATA_W-1:0]  acc_body [NUM_ACC];
    logic [GUARD_W-1:0] acc_grd  [NUM_ACC];
    logic [DATA_W-1:0]  opr_body [NUM_OPR];

    for (genvar a = 0; a < NUM_ACC; a++) begin : g_acc
        localparam logic [SEL_W-1:0] BODY_SEL = SEL_ACC_BASE + SEL_W'(a);
        localparam logic [SEL_W-1:0] GRD_SEL  = SEL_GRD_BASE + SEL_W'(a);
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_body[a] <= '0;
                acc_grd[a]  <= '0;
            end else if (wr_en && sel == BODY_SEL) begin
                acc_body[a] <= img_body;
                acc_grd[a]  <= img_guard;
            end else if (wr_en && sel == GRD_SEL) begin
                acc_grd[a]  <= grd_byte;
            end
        end
    end

    for (genvar o = 0; o < NUM_OPR; o++) begin : g_opr
        localparam logic [SEL_W-1:0] OPR_SEL = SEL_OPR_BASE + SEL_W'(o);
        always_ff @(posedge clk) begin
            if (rst)                         opr_body[o] <= '0;
            else if (wr_en && sel == OPR_SEL) opr_body[o] <= img_body;
        end
    end

    always_comb begin
        rd_body  = '0;
        rd_guard = '0;
        for (int a = 0; a < NUM_ACC; a++) begin
            if (sel == SEL_ACC_BASE + SEL_W'(a)) rd_body  = acc_body[a];
            if (sel == SEL_GRD_BASE + SEL_W'(a)) rd_guard = acc_grd[a];
        end
        for (int o = 0; o < NUM_OPR; o++) begin
            if (sel == SEL_OPR_BASE + SEL_W'(o)) rd_body = opr_body[o];
        end
    end
endmodule

// File: rtl/xfer_store_align.sv
`timescale 1ns/1ps
module xfer_store_align
    import dsp_xfer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8
) (
    input  xfer_kind_e         kind,
    input  logic               cmd_long,
    input  logic               sel_is_guard,
    input  logic [DATA_W-1:0]  rd_body,
    input  logic [GUARD_W-1:0] rd_guard,
    output logic [DATA_W-1:0]  st_data
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        st_data = '0;
        if (kind == XK_STORE) begin
            if (sel_is_guard)
                st_data = {{(DATA_W-GUARD_W){rd_guard[GUARD_W-1]}}, rd_guard};
            else if (cmd_long)
                st_data = rd_body;
            else
                st_data = {{HALF_W{rd_body[DATA_W-1]}}, rd_body[DATA_W-1:HALF_W]};
        end
    end
endmodule

// File: rtl/dsp_xfer_fmt.sv
`timescale 1ns/1ps
module dsp_xfer_fmt
    import dsp_xfer_pkg::*;
#(
    parameter int DATA_W  = dsp_xfer_pkg::DATA_W,
    parameter int GUARD_W = dsp_xfer_pkg::GUARD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_load,
    input  logic              cmd_long,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] st_data,
    output logic              cmd_illegal
);
    xfer_kind_e         kind;
    logic               sel_is_guard;
    logic [DATA_W-1:0]  img_body;
    logic [GUARD_W-1:0] img_guard;
    logic [GUARD_W-1:0] grd_byte;
    logic [DATA_W-1:0]  rd_body;
    logic [GUARD_W-1:0] rd_guard;

    xfer_decode u_dec (
        .cmd_valid    (cmd_valid),
        .cmd_load     (cmd_load),
        .cmd_sel      (cmd_sel),
        .kind         (kind),
        .sel_is_guard (sel_is_guard)
    );

    xfer_load_align #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_ld (
        .cmd_long  (cmd_long),
        .ld_data   (ld_data),
        .img_body  (img_body),
        .img_guard (img_guard),
        .grd_byte  (grd_byte)
    );

    xfer_regfile #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (kind == XK_LOAD),
        .sel       (cmd_sel),
        .img_body  (img_body),
        .img_guard (img_guard),
        .grd_byte  (grd_byte),
        .rd_body   (rd_body),
        .rd_guard  (rd_guard)
    );

    xfer_store_align #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_st (
        .kind         (kind),
        .cmd_long     (cmd_long),
        .sel_is_guard (sel_is_guard),
        .rd_body      (rd_body),
        .rd_guard     (rd_guard),
        .st_data      (st_data)
    );

    assign cmd_illegal = (kind == XK_REJECT);
endmodule

// File: rtl/dsp_xfer_chk.sv
`timescale 1ns/1ps
module dsp_xfer_chk
    import dsp_xfer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_load,
    input logic              cmd_long,
    input logic [SEL_W-1:0]  cmd_sel,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] st_data,
    input logic              cmd_illegal
);
    localparam int HALF_W = DATA_W / 2;

    logic plain_sel;
    assign plain_sel = (cmd_sel <= SEL_LAST_OK) &&
                       !((cmd_sel >= SEL_GRD_BASE) && (cmd_sel < SEL_OPR_BASE));

    p_illegal_decode_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_illegal == (cmd_valid && cmd_sel >= SEL_STATUS));

    p_no_bus_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_load || cmd_illegal) |-> st_data == '0);

    p_guard_store_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_load && cmd_sel >= SEL_GRD_BASE && cmd_sel < SEL_OPR_BASE)
        |-> st_data[DATA_W-1:GUARD_W] == {(DATA_W-GUARD_W){st_data[GUARD_W-1]}});

    p_word_store_ext_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_load && !cmd_long && plain_sel)
        |-> st_data[DATA_W-1:HALF_W] == {HALF_W{st_data[HALF_W-1]}});

    p_load_then_store_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid && cmd_load && cmd_long && cmd_sel >= SEL_OPR_BASE
               && cmd_sel <= SEL_LAST_OK) && !$past(rst)
         && cmd_valid && !cmd_load && cmd_long && cmd_sel == $past(cmd_sel))
        |-> st_data == $past(ld_data));

    p_acc_guard_ext_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid && cmd_load && cmd_sel == SEL_ACC_BASE) && !$past(rst)
         && cmd_valid && !cmd_load && cmd_sel == SEL_GRD_BASE)
        |-> st_data == {DATA_W{$past(cmd_long ? ld_data[DATA_W-1] : ld_data[HALF_W-1])}});
endmodule

bind dsp_xfer_fmt dsp_xfer_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (.*);

// File: tb/dsp_xfer_fmt_tb.sv
`timescale 1ns/1ps
module dsp_xfer_fmt_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_load = 1'b0;
    logic        cmd_long = 1'b0;
    logic [3:0]  cmd_sel = 4'd0;
    logic [31:0] ld_data = 32'd0;
    logic [31:0] st_data;
    logic        cmd_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] st;
        logic        ill;
    } exp_t;
    exp_t q[$];

    logic [31:0] m_acc [2];
    logic [7:0]  m_grd [2];
    logic [31:0] m_opr [4];

    always #2.5 clk = ~clk;

    dsp_xfer_fmt u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
        .cmd_long(cmd_long), .cmd_sel(cmd_sel), .ld_data(ld_data),
        .st_data(st_data), .cmd_illegal(cmd_illegal)
    );

    task automatic issue(input bit v, input bit ld, input bit lg,
                         input logic [3:0] sel, input logic [31:0] d, input string tag);
        exp_t e;
        logic [31:0] body;
        @(posedge clk);
        #1;
        cmd_valid = v; cmd_load = ld; cmd_long = lg; cmd_sel = sel; ld_data = d;
        e.tag = tag; e.st = 32'd0; e.ill = v && (sel >= 4'd8);
        if (v && sel <= 4'd7) begin
            if (!ld) begin
                if (sel == 4'd2 || sel == 4'd3) begin
                    e.st = {{24{m_grd[sel-2][7]}}, m_grd[sel-2]};
                end else begin
                    body = (sel < 4'd2) ? m_acc[sel[0]] : m_opr[sel-4];
                    e.st = lg ? body : {{16{body[31]}}, body[31:16]};
                end
            end else begin
                body = lg ? d : {d[15:0], 16'h0000};
                if (sel < 4'd2) begin
                    m_acc[sel[0]] = body;
                    m_grd[sel[0]] = {8{body[31]}};
                end else if (sel < 4'd4) begin
                    m_grd[sel-2] = d[7:0];
                end else begin
                    m_opr[sel-4] = body;
                end
            end
        end
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (st_data !== e.st || cmd_illegal !== e.ill) begin
                errors++;
                $display("FAIL %s: st_data=%h illegal=%b expected st_data=%h illegal=%b",
                         e.tag, st_data, cmd_illegal, e.st, e.ill);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_grd[i] = '0; end
        for (int i = 0; i < 4; i++) m_opr[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int s = 0; s < 8; s++)
            issue(1, 0, 1, 4'(s), 32'h0, "R1 R2 reset longword read");
        issue(1, 0, 0, 4'd2, 32'h0, "R2 reset guard0");

        issue(1, 1, 1, 4'd4, 32'h8123_4567, "R4 long load opr0");
        issue(1, 0, 1, 4'd4, 32'h0, "R4 R11 long store opr0");
        issue(1, 1, 0, 4'd5, 32'hDEAD_1234, "R3 word load opr1");
        issue(1, 0, 1, 4'd5, 32'h0, "R3 long store opr1");
        issue(1, 0, 0, 4'd5, 32'h0, "R8 word store positive");
        issue(1, 1, 0, 4'd6, 32'h0000_9ABC, "R3 word load opr2");
        issue(1, 0, 0, 4'd6, 32'h0, "R8 word store negative");
        issue(1, 0, 0, 4'd4, 32'h0, "R8 word store opr0");

        issue(1, 1, 1, 4'd0, 32'h8000_0001, "R5 long load acc0");
        issue(1, 0, 0, 4'd2, 32'h0, "R5 R7 guard0 after negative load");
        issue(1, 0, 1, 4'd0, 32'h0, "R9 long store acc0 body only");
        issue(1, 0, 0, 4'd0, 32'h0, "R8 word store acc0");
        issue(1, 1, 0, 4'd1, 32'h1111_7FFF, "R3 R5 word load acc1");
        issue(1, 0, 1, 4'd3, 32'h0, "R5 guard1 after positive word load");
        issue(1, 1, 0, 4'd1, 32'h0000_8000, "R5 word load acc1 negative");
        issue(1, 0, 0, 4'd3, 32'h0, "R5 guard1 from word bit 15");

        issue(1, 1, 0, 4'd3, 32'hABCD_0080, "R6 word load guard1");
        issue(1, 0, 1, 4'd3, 32'h0, "R6 R7 long store guard1");
        issue(1, 0, 1, 4'd1, 32'h0, "R6 acc1 body unchanged");
        issue(1, 0, 1, 4'd2, 32'h0, "R6 guard0 unchanged");
        issue(1, 1, 1, 4'd2, 32'h1234_5642, "R6 long load guard0");
        issue(1, 0, 0, 4'd2, 32'h0, "R6 R7 guard0 positive");
        issue(1, 0, 1, 4'd0, 32'h0, "R6 acc0 body unchanged");

        issue(1, 1, 1, 4'd8, 32'hFFFF_FFFF, "R10 load status flagged");
        issue(1, 0, 1, 4'd8, 32'h0, "R10 store status flagged");
        issue(1, 1, 1, 4'd15, 32'hFFFF_FFFF, "R10 load unused selector");
        issue(1, 0, 1, 4'd4, 32'h0, "R10 opr0 unchanged after reject");
        issue(1, 0, 1, 4'd7, 32'h0, "R10 opr3 unchanged after reject");

        issue(0, 0, 1, 4'd4, 32'h0, "R11 idle bus zero");
        issue(0, 1, 1, 4'd9, 32'h0, "R10 R11 invalid command not flagged");
        issue(1, 1, 1, 4'd7, 32'h5A5A_A5A5, "R11 load cycle bus zero");
        issue(1, 0, 1, 4'd7, 32'h0, "R11 back to back store opr3");
        issue(1, 1, 0, 4'd7, 32'hFFFF_C3C3, "R3 R11 word load opr3");
        issue(1, 0, 0, 4'd7, 32'h0, "R8 R11 word store opr3");

        issue(0, 0, 0, 4'd0, 32'h0, "R11 final idle");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule